// File: doc/BRIEF.md
# Keyboard Controller Core Power-Down Sequencer

This block puts a small embedded keyboard-controller CPU core to sleep and wakes it up again. The instruction decoder raises a halt request or a stop request. A halt request parks the core in a light sleep: the core is stalled and the clock source keeps running. A stop request parks it in a deep sleep: the core is stalled and the oscillator enable is dropped as well.

Two events end either sleep. One is the core reset input. The other is a host write of a byte into the input data buffer. A light sleep ends on the next clock. A deep sleep first turns the oscillator back on. The core then stays stalled for a settling interval, which is programmed through `settle_len` (a value of zero selects a default of 1024 cycles).

When the stall is released, a one-cycle resume pulse carries a cause code. The core uses this code to decide whether to continue with the next instruction, call the input-buffer-full interrupt routine, or run its reset sequence from address zero.

Top module: `kbc_pwr_ctrl`

## Requirements
- R1: After `rst_n` is released, `stall` is 0, `osc_en` is 1 and `resume_vld` is 0.
- R2: When `halt_req` is high at a clock edge in the running state, `stall` is 1 from the next cycle on and `osc_en` stays 1.
- R3: When `stop_req` is high at a clock edge in the running state, `stall` is 1 and `osc_en` is 0 from the next cycle on. If `halt_req` and `stop_req` are both high, the stop request wins.
- R4: In light sleep, a clock edge with `host_wr` or `core_rst` high makes `stall` 0 in the next cycle. A resume pulse is issued in that same cycle.
- R5: The cause code on `resume_cause` is valid while `resume_vld` is high. The codes are: 2'b00 for a host-write wake with `ibf_irq_en` = 0 (continue), 2'b01 for a host-write wake with `ibf_irq_en` = 1 (take interrupt), and 2'b10 for a reset wake (restart). `restart_zero` is high exactly when a pulse carries 2'b10.
- R6: Reset takes priority over a host write. If both are high at the wake edge, the cause is 2'b10. A `core_rst` seen during oscillator settling also turns the pending cause into 2'b10.
- R7: In deep sleep, a wake edge sets `osc_en` to 1 from the next cycle on. `stall` then stays 1 for exactly N cycles after that edge, where N is `settle_len`, or 1024 when `settle_len` is 0. The resume pulse comes in the first cycle with `stall` at 0.
- R8: A `halt_req` or `stop_req` while `stall` is 1 is ignored. `stall` stays 1 and `osc_en` keeps its value.
- R9: In the running state, a `halt_req` or `stop_req` at an edge where `core_rst` is high is ignored, and `stall` stays 0.
- R10: `resume_vld` is high for exactly one cycle per wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset of this block |
| halt_req | input | 1 | Light-sleep request from the instruction decoder |
| stop_req | input | 1 | Deep-sleep request from the instruction decoder |
| core_rst | input | 1 | Core reset request, also a wake source |
| host_wr | input | 1 | Host wrote a byte into the input data buffer |
| ibf_irq_en | input | 1 | Input-buffer-full interrupt enable |
| settle_len | input | CNT_W | Oscillator settling length in cycles, 0 selects the default |
| stall | output | 1 | Core execution stall |
| osc_en | output | 1 | Oscillator enable |
| resume_vld | output | 1 | One-cycle resume pulse |
| resume_cause | output | 2 | Resume cause code, valid with `resume_vld` |
| restart_zero | output | 1 | Restart at program address zero, valid with `resume_vld` |

## Verification
The bench runs every combination of sleep depth and wake source: a host write with the interrupt disabled, a host write with it enabled, a reset, and a reset together with a host write. The first three separate the three cause codes. The combined case shows whether reset priority is honoured.

Deep-sleep wakes are repeated over several settling lengths and over the zero-selects-default case. Counting the stalled cycles shows whether the timer is off by one and whether the default length is applied.

Sleep requests are issued during sleep and during a reset in the running state. Observing `osc_en` and `stall` afterwards shows whether those requests are dropped. A reset issued partway through settling shows whether the pending cause is upgraded to a restart.

// File: rtl/kbc_pwr_pkg.sv
package kbc_pwr_pkg;
    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_SOFT   = 2'd1,
        PS_HARD   = 2'd2,
        PS_SETTLE = 2'd3
    } pstate_e;

    localparam logic [1:0] CAUSE_CONT = 2'b00;
    localparam logic [1:0] CAUSE_IRQ  = 2'b01;
    localparam logic [1:0] CAUSE_RST  = 2'b10;

    function automatic logic [1:0] wake_cause(input logic rst, input logic irq_en);
        if (rst) begin
            return CAUSE_RST;
        end
        return irq_en ? CAUSE_IRQ : CAUSE_CONT;
    endfunction
endpackage

// File: rtl/kbc_settle_timer.sv
module kbc_settle_timer #(
    parameter int CNT_W       = 11,
    parameter int DEF_SETTLE  = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    localparam logic [CNT_W-1:0] DEF_LEN = CNT_W'(DEF_SETTLE);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W-1:0] len_eff;

    always_comb begin
        len_eff = (len == '0) ? DEF_LEN : len;
        tmr_d   = tmr_q;
        if (start) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = len_eff;
        end else if (tmr_q.active) begin
            if (tmr_q.cnt == ONE) begin
                tmr_d.active = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = tmr_q.active && (tmr_q.cnt == ONE);
endmodule

// File: rtl/kbc_pwr_fsm.sv
module kbc_pwr_fsm
    import kbc_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       stop_req,
    input  logic       core_rst,
    input  logic       host_wr,
    input  logic       ibf_irq_en,
    input  logic       tmr_done,
    output logic       tmr_start,
    output pstate_e    state,
    output logic       pulse,
    output logic [1:0] cause
);
    typedef struct packed {
        pstate_e    state;
        logic       pulse;
        logic [1:0] cause;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic wake;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.pulse = 1'b0;
        tmr_start   = 1'b0;
        wake        = core_rst || host_wr;
        unique case (fsm_q.state)
            PS_RUN: begin
                if (!core_rst) begin
                    if (stop_req) begin
                        fsm_d.state = PS_HARD;
                    end else if (halt_req) begin
                        fsm_d.state = PS_SOFT;
                    end
                end
            end
            PS_SOFT: begin
                if (wake) begin
                    fsm_d.state = PS_RUN;
                    fsm_d.pulse = 1'b1;
                    fsm_d.cause = wake_cause(core_rst, ibf_irq_en);
                end
            end
            PS_HARD: begin
                if (wake) begin
                    fsm_d.state = PS_SETTLE;
                    fsm_d.cause = wake_cause(core_rst, ibf_irq_en);
                    tmr_start   = 1'b1;
                end
            end
            PS_SETTLE: begin
                if (core_rst) begin
                    fsm_d.cause = CAUSE_RST;
                end
                if (tmr_done) begin
                    fsm_d.state = PS_RUN;
                    fsm_d.pulse = 1'b1;
                end
            end
            default: fsm_d.state = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: PS_RUN, pulse: 1'b0, cause: CAUSE_CONT};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.state;
    assign pulse = fsm_q.pulse;
    assign cause = fsm_q.cause;
endmodule

// File: rtl/kbc_pwr_ctrl.sv
module kbc_pwr_ctrl
    import kbc_pwr_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int DEF_SETTLE = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             stop_req,
    input  logic             core_rst,
    input  logic             host_wr,
    input  logic             ibf_irq_en,
    input  logic [CNT_W-1:0] settle_len,
    output logic             stall,
    output logic             osc_en,
    output logic             resume_vld,
    output logic [1:0]       resume_cause,
    output logic             restart_zero
);
    logic    tmr_start;
    logic    tmr_done;
    pstate_e state;
    logic    pulse;
    logic [1:0] cause;

    kbc_pwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_req   (halt_req),
        .stop_req   (stop_req),
        .core_rst   (core_rst),
        .host_wr    (host_wr),
        .ibf_irq_en (ibf_irq_en),
        .tmr_done   (tmr_done),
        .tmr_start  (tmr_start),
        .state      (state),
        .pulse      (pulse),
        .cause      (cause)
    );

    kbc_settle_timer #(
        .CNT_W      (CNT_W),
        .DEF_SETTLE (DEF_SETTLE)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .len   (settle_len),
        .done  (tmr_done)
    );

    assign stall        = (state != PS_RUN);
    assign osc_en       = (state != PS_HARD);
    assign resume_vld   = pulse;
    assign resume_cause = cause;
    assign restart_zero = pulse && (cause == CAUSE_RST);
endmodule

// File: rtl/kbc_pwr_ctrl_chk.sv
module kbc_pwr_ctrl_chk #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt_req,
    input logic             stop_req,
    input logic             core_rst,
    input logic             host_wr,
    input logic             ibf_irq_en,
    input logic [CNT_W-1:0] settle_len,
    input logic             stall,
    input logic             osc_en,
    input logic             resume_vld,
    input logic [1:0]       resume_cause,
    input logic             restart_zero
);
    AST_OSC_OFF_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> stall); // R3

    AST_OSC_FALL_BY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> $past(stop_req) && !$past(stall)); // R8

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld |=> !resume_vld); // R10

    AST_PULSE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld |-> !stall && $past(stall)); // R4

    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld |-> resume_cause != 2'b11); // R5

    AST_RESTART_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        restart_zero |-> resume_vld && resume_cause == 2'b10); // R5

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld && $past(core_rst) |-> resume_cause == 2'b10); // R6

    AST_RUN_RST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !stall && core_rst |=> !stall); // R9
endmodule

bind kbc_pwr_ctrl kbc_pwr_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_kbc_pwr_ctrl.sv
module tb_kbc_pwr_ctrl;
    localparam int CNT_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 1'b0, stop_req = 1'b0, core_rst = 1'b0, host_wr = 1'b0;
    logic ibf_irq_en = 1'b0;
    logic [CNT_W-1:0] settle_len = '0;
    logic stall, osc_en, resume_vld, restart_zero;
    logic [1:0] resume_cause;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    kbc_pwr_ctrl #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
        .core_rst(core_rst), .host_wr(host_wr), .ibf_irq_en(ibf_irq_en),
        .settle_len(settle_len), .stall(stall), .osc_en(osc_en),
        .resume_vld(resume_vld), .resume_cause(resume_cause),
        .restart_zero(restart_zero)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // mode 0 = light sleep, 1 = deep sleep; src 0 host en0, 1 host en1, 2 reset, 3 both
    task automatic run_case(input int mode, input int src, input int len, input bit mid_rst);
        int exp_n, exp_cause, cnt;
        exp_n     = (len == 0) ? 1024 : len;
        exp_cause = (src >= 2) ? 2 : src;
        if (mid_rst) exp_cause = 2;
        ibf_irq_en = (src == 1 || src == 3);
        settle_len = CNT_W'(len);
        if (mode == 0) halt_req = 1'b1; else stop_req = 1'b1;
        tick(1);
        halt_req = 1'b0; stop_req = 1'b0;
        check("R2/R3 stall after request", stall, 1);
        check("R2/R3 osc_en in sleep", osc_en, (mode == 0) ? 1 : 0);
        // R8: other requests while asleep
        halt_req = 1'b1; stop_req = 1'b1;
        tick(2);
        halt_req = 1'b0; stop_req = 1'b0;
        tick(1);
        check("R8 stall kept", stall, 1);
        check("R8 osc_en kept", osc_en, (mode == 0) ? 1 : 0);
        host_wr  = (src != 2);
        core_rst = (src >= 2);
        tick(1);
        host_wr = 1'b0; core_rst = 1'b0;
        if (mode == 0) begin
            check("R4 stall released", stall, 0);
            check("R4 resume pulse", resume_vld, 1);
            check("R5/R6 cause", resume_cause, exp_cause);
            check("R5 restart_zero", restart_zero, (exp_cause == 2) ? 1 : 0);
        end else begin
            check("R7 osc_en back on", osc_en, 1);
            cnt = 0;
            while (stall && cnt < 3000) begin
                if (mid_rst && cnt == 1) core_rst = 1'b1;
                tick(1);
                core_rst = 1'b0;
                cnt++;
                if (stall) check("R10 no pulse while stalled", resume_vld, 0);
            end
            check("R7 settle length", cnt, exp_n);
            check("R7 resume pulse", resume_vld, 1);
            check("R5/R6 cause", resume_cause, exp_cause);
            check("R5 restart_zero", restart_zero, (exp_cause == 2) ? 1 : 0);
        end
        tick(1);
        check("R10 pulse one cycle", resume_vld, 0);
        check("R10 still running", stall, 0);
        tick(1);
    endtask

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R1 stall", stall, 0);
        check("R1 osc_en", osc_en, 1);
        check("R1 resume_vld", resume_vld, 0);

        // R9: requests during running-state reset are dropped
        core_rst = 1'b1; halt_req = 1'b1; stop_req = 1'b1;
        tick(1);
        core_rst = 1'b0; halt_req = 1'b0; stop_req = 1'b0;
        check("R9 stall stays low", stall, 0);
        check("R9 osc_en stays high", osc_en, 1);
        check("R9 no pulse", resume_vld, 0);

        // R3: stop beats halt in the same cycle
        halt_req = 1'b1; stop_req = 1'b1;
        tick(1);
        halt_req = 1'b0; stop_req = 1'b0;
        check("R3 stop wins", osc_en, 0);
        host_wr = 1'b1; settle_len = CNT_W'(2);
        tick(1);
        host_wr = 1'b0;
        tick(4);
        check("R3 recovered", stall, 0);

        for (int src = 0; src < 4; src++) run_case(0, src, 1, 1'b0);
        for (int src = 0; src < 4; src++) begin
            for (int li = 0; li < 4; li++) begin
                run_case(1, src, (li == 3) ? 7 : li + 1, 1'b0);
            end
        end
        run_case(1, 1, 0, 1'b0);  // R7 default length
        run_case(1, 1, 6, 1'b1);  // R6 reset during settling
        run_case(1, 0, 5, 1'b1);  // R6 reset during settling

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule